// File: doc/BRIEF.md
# Reset Source Recorder and One-Shot Reset

This block keeps a sticky record of what caused the most recent reset and lets software trigger reset pulses of its own. Single-cycle event pulses arrive from the power-on detector, the external reset pin, the watchdog, the low-voltage monitor, the brownout monitor, the processor's system reset request and the debugger. Each recognised event sets its own status flag. The flags live in an always-on domain that only the true power-on reset `rst_ni` clears. Software clears a flag by writing 1 to it.

A control register holds two self-clearing trigger bits. One drives a whole-chip reset and the other a processor-only reset. Each bit holds its reset output for a fixed window of `PULSE_CYCLES` clocks and then clears itself. A 16-bit power-on code register turns the power-on detector off while it holds the key value 0x5AA5. Any hardware reset other than a processor system request, and any software chip reset, returns that register to zero, which turns the detector back on. Writes to the control register and the code register take effect only while `unlock_i` is high. Write protection itself is provided outside this block.

Registers are selected by `addr_i`:
- 0 is the status flags.
- 1 is the control bits: bit 0 chip, bit 1 processor.
- 2 is the power-on code.
- 3 reads as zero.

Top module: `rst_src_rec`

## Requirements
- R1: After `rst_ni` the status register reads 0x01, the control and code registers read 0, `chip_rst_o` and `cpu_rst_o` are low, and `por_det_en_o` is high.
- R2: An event pulse sets its status flag at the next clock edge. The positions are pin bit 1, watchdog bit 2, low-voltage bit 3, brownout bit 4 and system request bit 5. When several events arrive in the same cycle, every matching flag is set.
- R3: Writing the status register clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. A flag that is set and cleared in the same cycle ends up set.
- R4: An unlocked control write with bit 0 set raises `chip_rst_o` from the next cycle for exactly `PULSE_CYCLES` (2) cycles. During that window control bit 0 reads 1, and it reads 0 afterwards. The write also sets status bit 0.
- R5: An unlocked control write with bit 1 set raises `cpu_rst_o` for exactly 2 cycles and sets status bit 7. It leaves `chip_rst_o` low.
- R6: While `unlock_i` is low, writes to the control register and the code register have no effect.
- R7: While the code register holds 0x5AA5, `por_det_en_o` is low and a power-on event neither sets status bit 0 nor asserts `chip_rst_o`. With any other code value, a power-on event sets bit 0 and asserts `chip_rst_o` for one cycle.
- R8: A pin, watchdog, low-voltage, brownout or debugger event, or a chip one-shot write, resets the code register to 0. A system request event or a processor one-shot write leaves the code register unchanged.
- R9: Status bit 6 and all bits above bit 7 read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous true power-on reset |
| unlock_i | input | 1 | Protection unlocked; gates control and code writes |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` |
| evt_por_i | input | 1 | Power-on detector event |
| evt_pin_i | input | 1 | External reset pin event |
| evt_wdt_i | input | 1 | Watchdog reset event |
| evt_lvr_i | input | 1 | Low-voltage reset event |
| evt_bod_i | input | 1 | Brownout reset event |
| evt_sysreq_i | input | 1 | Processor system reset request |
| evt_dbg_i | input | 1 | Debugger reset command |
| chip_rst_o | output | 1 | Whole-chip reset request |
| cpu_rst_o | output | 1 | Processor-only reset request |
| por_det_en_o | output | 1 | Power-on detector enabled |

## Verification
The flag logic is exercised with three input patterns:
- A lone event shows that each source lands on its own bit.
- Events arriving together show that simultaneous sources are not lost.
- An event that coincides with a clearing write shows which of the two takes priority.

The one-shot outputs are sampled in every cycle of their window, which separates a two-cycle pulse from a pulse that is one cycle short or one cycle long. The power-on code is written with the key value and with a non-key value, and writes are tried both locked and unlocked. It is then re-armed by each kind of source, which separates the sources that re-arm the detector from the system request and processor one-shot, which must not.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned FLAG_W = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS  = 2'd0,
    RA_CTRL    = 2'd1,
    RA_PORCODE = 2'd2,
    RA_NONE    = 2'd3
  } reg_addr_e;

  localparam int unsigned FB_POR = 0;
  localparam int unsigned FB_PIN = 1;
  localparam int unsigned FB_WDT = 2;
  localparam int unsigned FB_LVR = 3;
  localparam int unsigned FB_BOD = 4;
  localparam int unsigned FB_SYS = 5;
  localparam int unsigned FB_CPU = 7;

  localparam logic [FLAG_W-1:0] FLAG_VALID = 8'b1011_1111;
  localparam logic [FLAG_W-1:0] FLAG_RST   = 8'b0000_0001;

  localparam int unsigned NUM_OS = 2;
  localparam int unsigned OS_CHIP = 0;
  localparam int unsigned OS_CPU  = 1;
endpackage

// File: rtl/rsr_oneshot.sv
module rsr_oneshot #(
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      cnt_q <= CW'(PULSE_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rsr_flags.sv
module rsr_flags
  import rsr_pkg::*;
#(
  parameter logic [FLAG_W-1:0] VALID = FLAG_VALID,
  parameter logic [FLAG_W-1:0] RST_V = FLAG_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (VALID[i]) begin : g_flop
      logic f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= RST_V[i];
        else         f_q <= set_i[i] | (f_q & ~clr_i[i]);  // set wins
      end
      assign flags_o[i] = f_q;
    end else begin : g_tie
      logic unused_set, unused_clr;
      assign unused_set = set_i[i];
      assign unused_clr = clr_i[i];
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rsr_por_ctl.sv
module rsr_por_ctl #(
  parameter int unsigned        CODE_W  = 16,
  parameter logic [CODE_W-1:0]  POR_KEY = 16'h5AA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              rearm_i,
  output logic [CODE_W-1:0] code_o,
  output logic              det_en_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (rearm_i) code_q <= '0;       // reset from another source wins
    else if (wr_i)    code_q <= wdata_i;
  end

  assign code_o   = code_q;
  assign det_en_o = (code_q != POR_KEY);
endmodule

// File: rtl/rst_src_rec.sv
module rst_src_rec
  import rsr_pkg::*;
#(
  parameter int unsigned       DW           = 32,
  parameter int unsigned       PULSE_CYCLES = 2,
  parameter int unsigned       CODE_W       = 16,
  parameter logic [CODE_W-1:0] POR_KEY      = 16'h5AA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              evt_por_i,
  input  logic              evt_pin_i,
  input  logic              evt_wdt_i,
  input  logic              evt_lvr_i,
  input  logic              evt_bod_i,
  input  logic              evt_sysreq_i,
  input  logic              evt_dbg_i,
  output logic              chip_rst_o,
  output logic              cpu_rst_o,
  output logic              por_det_en_o
);
  logic              stat_wr, ctrl_wr, code_wr;
  logic [NUM_OS-1:0] os_trig, os_act;
  logic [FLAG_W-1:0] flag_set, flag_clr, flags;
  logic [CODE_W-1:0] code;
  logic              det_en, por_acc, por_pulse_q, rearm;
  logic              unused_wd;

  assign unused_wd = ^wdata_i[DW-1:CODE_W];

  assign stat_wr = wr_en_i && (addr_i == RA_STATUS);
  assign ctrl_wr = wr_en_i && (addr_i == RA_CTRL) && unlock_i;
  assign code_wr = wr_en_i && (addr_i == RA_PORCODE) && unlock_i;

  for (genvar g = 0; g < NUM_OS; g++) begin : g_os
    assign os_trig[g] = ctrl_wr & wdata_i[g];
    rsr_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_os (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (os_trig[g]),
      .active_o(os_act[g])
    );
  end

  assign por_acc = evt_por_i & det_en;

  always_comb begin
    flag_set         = '0;
    flag_set[FB_POR] = por_acc | os_trig[OS_CHIP];
    flag_set[FB_PIN] = evt_pin_i;
    flag_set[FB_WDT] = evt_wdt_i;
    flag_set[FB_LVR] = evt_lvr_i;
    flag_set[FB_BOD] = evt_bod_i;
    flag_set[FB_SYS] = evt_sysreq_i;
    flag_set[FB_CPU] = os_trig[OS_CPU];
  end

  assign flag_clr = stat_wr ? wdata_i[FLAG_W-1:0] : '0;

  rsr_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flags_o(flags)
  );

  assign rearm = evt_pin_i | evt_wdt_i | evt_lvr_i | evt_bod_i | evt_dbg_i
               | os_trig[OS_CHIP];

  rsr_por_ctl #(.CODE_W(CODE_W), .POR_KEY(POR_KEY)) u_por (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (code_wr),
    .wdata_i (wdata_i[CODE_W-1:0]),
    .rearm_i (rearm),
    .code_o  (code),
    .det_en_o(det_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_pulse_q <= 1'b0;
    else         por_pulse_q <= por_acc;
  end

  assign chip_rst_o   = os_act[OS_CHIP] | por_pulse_q;
  assign cpu_rst_o    = os_act[OS_CPU];
  assign por_det_en_o = det_en;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_STATUS:  rdata_o[FLAG_W-1:0] = flags;
      RA_CTRL:    rdata_o[NUM_OS-1:0] = os_act;
      RA_PORCODE: rdata_o[CODE_W-1:0] = code;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rst_src_rec_chk.sv
module rst_src_rec_chk
  import rsr_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned DW           = 32,
  parameter int unsigned CODE_W       = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unlock_i,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              evt_por_i,
  input logic              evt_pin_i,
  input logic              evt_wdt_i,
  input logic              evt_lvr_i,
  input logic              evt_bod_i,
  input logic              evt_sysreq_i,
  input logic              evt_dbg_i,
  input logic [FLAG_W-1:0] flags,
  input logic [CODE_W-1:0] code,
  input logic [NUM_OS-1:0] os_act,
  input logic              por_pulse_q,
  input logic              det_en
);
  logic              ctrl_w, chip_trig, cpu_trig;
  logic [FLAG_W-1:0] clr_v;
  logic [3:0]        chip_run_q, cpu_run_q;

  assign ctrl_w    = wr_en_i && (addr_i == RA_CTRL) && unlock_i;
  assign chip_trig = ctrl_w && wdata_i[0];
  assign cpu_trig  = ctrl_w && wdata_i[1];
  assign clr_v     = (wr_en_i && addr_i == RA_STATUS) ? wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_run_q <= '0;
      cpu_run_q  <= '0;
    end else begin
      if (chip_trig)                         chip_run_q <= 4'd1;
      else if (os_act[0] && chip_run_q != '1) chip_run_q <= chip_run_q + 1'b1;
      else if (!os_act[0])                   chip_run_q <= '0;
      if (cpu_trig)                          cpu_run_q <= 4'd1;
      else if (os_act[1] && cpu_run_q != '1)  cpu_run_q <= cpu_run_q + 1'b1;
      else if (!os_act[1])                   cpu_run_q <= '0;
    end
  end

  AST_CHIP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_act[0] |-> (chip_run_q >= 4'd1 && chip_run_q <= 4'(PULSE_CYCLES))); // R4
  AST_CPU_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_act[1] |-> (cpu_run_q >= 4'd1 && cpu_run_q <= 4'(PULSE_CYCLES))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags) & ~flags & ~$past(clr_v)) == '0)); // R3
  AST_SYSREQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_sysreq_i |=> flags[FB_SYS]); // R2
  AST_LOCKED_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_CTRL && !unlock_i && os_act == '0) |=> (os_act == '0)); // R6
  AST_POR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_en && evt_por_i) |=> !por_pulse_q); // R7
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_pin_i || evt_wdt_i || evt_lvr_i || evt_bod_i || evt_dbg_i) |=> (code == '0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[6] == 1'b0); // R9
endmodule

bind rst_src_rec rst_src_rec_chk #(
  .PULSE_CYCLES(PULSE_CYCLES), .DW(DW), .CODE_W(CODE_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .unlock_i(unlock_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .evt_por_i(evt_por_i),
  .evt_pin_i(evt_pin_i), .evt_wdt_i(evt_wdt_i), .evt_lvr_i(evt_lvr_i),
  .evt_bod_i(evt_bod_i), .evt_sysreq_i(evt_sysreq_i), .evt_dbg_i(evt_dbg_i),
  .flags(flags), .code(code), .os_act(os_act), .por_pulse_q(por_pulse_q),
  .det_en(det_en)
);

// File: tb/rst_src_rec_tb_top.sv
module rst_src_rec_tb_top;
  localparam int DW = 32;
  localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_PC = 2'd2, A_NO = 2'd3;
  localparam logic [6:0] E_POR = 7'h01, E_PIN = 7'h02, E_WDT = 7'h04,
                         E_LVR = 7'h08, E_BOD = 7'h10, E_SYS = 7'h20, E_DBG = 7'h40;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          unlock = 1'b0, wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [6:0]    evt = '0;
  logic          chip_rst, cpu_rst, det_en;
  int            checks = 0, errors = 0;
  logic [DW-1:0] rv;

  always #4 clk = ~clk;

  rst_src_rec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .evt_por_i(evt[0]), .evt_pin_i(evt[1]), .evt_wdt_i(evt[2]),
    .evt_lvr_i(evt[3]), .evt_bod_i(evt[4]), .evt_sysreq_i(evt[5]),
    .evt_dbg_i(evt[6]), .chip_rst_o(chip_rst), .cpu_rst_o(cpu_rst),
    .por_det_en_o(det_en)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d, input logic unl);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; unlock = unl;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    reg_rd(A_ST, rv); check("R1 status", rv, 32'h01);
    reg_rd(A_CT, rv); check("R1 ctrl", rv, 32'h0);
    reg_rd(A_PC, rv); check("R1 code", rv, 32'h0);
    check("R1 outputs", {29'd0, chip_rst, cpu_rst, det_en}, 32'h1);
  endtask

  task automatic t_events;
    reg_wr(A_ST, 32'hFF, 1'b0);
    reg_rd(A_ST, rv); check("R3 clear all", rv, 32'h0);
    pulse(E_PIN);
    reg_rd(A_ST, rv); check("R2 pin", rv, 32'h02);
    pulse(E_WDT | E_LVR | E_BOD);
    reg_rd(A_ST, rv); check("R2 simultaneous", rv, 32'h1E);
    pulse(E_SYS);
    reg_rd(A_ST, rv); check("R2 sysreq", rv, 32'h3E);
  endtask

  task automatic t_w1c;
    reg_wr(A_ST, 32'h06, 1'b0);
    reg_rd(A_ST, rv); check("R3 partial clear", rv, 32'h38);
    reg_wr(A_ST, 32'h00, 1'b0);
    reg_rd(A_ST, rv); check("R3 write zero", rv, 32'h38);
    @(negedge clk);
    evt = E_LVR; wr_en = 1'b1; addr = A_ST; wdata = 32'h08;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    reg_rd(A_ST, rv); check("R3 set wins", rv, 32'h38);
    reg_wr(A_ST, 32'hFF, 1'b0);
  endtask

  task automatic t_chip_os;
    reg_wr(A_CT, 32'h1, 1'b1);
    check("R4 chip c1", {31'd0, chip_rst}, 32'h1);
    check("R4 cpu low", {31'd0, cpu_rst}, 32'h0);
    reg_rd(A_CT, rv); check("R4 ctrl bit", rv, 32'h1);
    reg_rd(A_ST, rv); check("R4 por flag", rv, 32'h01);
    @(negedge clk); check("R4 chip c2", {31'd0, chip_rst}, 32'h1);
    @(negedge clk); check("R4 chip c3", {31'd0, chip_rst}, 32'h0);
    reg_rd(A_CT, rv); check("R4 ctrl cleared", rv, 32'h0);
    reg_wr(A_ST, 32'hFF, 1'b0);
  endtask

  task automatic t_cpu_os;
    reg_wr(A_CT, 32'h2, 1'b1);
    check("R5 cpu c1", {31'd0, cpu_rst}, 32'h1);
    check("R5 chip low", {31'd0, chip_rst}, 32'h0);
    reg_rd(A_ST, rv); check("R5 cpu flag", rv, 32'h80);
    @(negedge clk); check("R5 cpu c2", {31'd0, cpu_rst}, 32'h1);
    @(negedge clk); check("R5 cpu c3", {31'd0, cpu_rst}, 32'h0);
    reg_wr(A_ST, 32'hFF, 1'b0);
  endtask

  task automatic t_locked;
    reg_wr(A_CT, 32'h3, 1'b0);
    check("R6 no reset", {30'd0, chip_rst, cpu_rst}, 32'h0);
    reg_rd(A_ST, rv); check("R6 no flags", rv, 32'h0);
    reg_wr(A_PC, 32'h5AA5, 1'b0);
    reg_rd(A_PC, rv); check("R6 code locked", rv, 32'h0);
    check("R6 det_en", {31'd0, det_en}, 32'h1);
  endtask

  task automatic t_por_code;
    pulse(E_POR);
    check("R7 por pulse", {31'd0, chip_rst}, 32'h1);
    reg_rd(A_ST, rv); check("R7 por flag", rv, 32'h01);
    @(negedge clk); check("R7 por one cycle", {31'd0, chip_rst}, 32'h0);
    reg_wr(A_ST, 32'hFF, 1'b0);
    reg_wr(A_PC, 32'h1234, 1'b1);
    reg_rd(A_PC, rv); check("R7 code other", rv, 32'h1234);
    check("R7 det on", {31'd0, det_en}, 32'h1);
    reg_wr(A_PC, 32'h5AA5, 1'b1);
    check("R7 det off", {31'd0, det_en}, 32'h0);
    pulse(E_POR);
    check("R7 masked reset", {31'd0, chip_rst}, 32'h0);
    reg_rd(A_ST, rv); check("R7 masked flag", rv, 32'h0);
  endtask

  task automatic t_rearm;
    pulse(E_SYS);
    reg_rd(A_PC, rv); check("R8 sysreq keeps", rv, 32'h5AA5);
    reg_wr(A_CT, 32'h2, 1'b1);
    reg_rd(A_PC, rv); check("R8 cpu os keeps", rv, 32'h5AA5);
    repeat (3) @(negedge clk);
    pulse(E_WDT);
    reg_rd(A_PC, rv); check("R8 wdt rearm", rv, 32'h0);
    check("R8 det on", {31'd0, det_en}, 32'h1);
    reg_wr(A_PC, 32'h5AA5, 1'b1);
    pulse(E_DBG);
    reg_rd(A_PC, rv); check("R8 dbg rearm", rv, 32'h0);
    reg_wr(A_PC, 32'h5AA5, 1'b1);
    reg_wr(A_CT, 32'h1, 1'b1);
    reg_rd(A_PC, rv); check("R8 chip os rearm", rv, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reserved;
    reg_wr(A_ST, 32'hFFFF_FFFF, 1'b0);
    pulse(7'h3E);
    reg_rd(A_ST, rv); check("R9 reserved bits", rv & 32'hFFFF_FF40, 32'h0);
    reg_rd(A_NO, rv); check("R9 addr 3", rv, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_events;
    t_w1c;
    t_chip_os;
    t_cpu_os;
    t_locked;
    t_por_code;
    t_rearm;
    t_reserved;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule